// File: doc/BRIEF.md
# Four-Lane Source-Synchronous Frame Transmitter

This block sits behind a sample readout engine. A one-cycle load strobe hands it three 16-bit samples. It copies them into a staging store of eight 16-bit entries: the samples fill the lowest entries and the rest are padded with zeros, which gives a fixed 128-bit frame. It then waits for the receiver's acknowledge line. Once acknowledge is sampled high, it sends the whole frame over four data lanes together with a clock that it generates and forwards. The link runs at double data rate: a new nibble is presented on every edge of the forwarded clock.

The forwarded clock runs at half the block's own clock. Each system cycle of the send phase toggles the forwarded clock and presents a new nibble. A 200 MHz system clock therefore gives a 100 MHz link clock, and the frame takes 16 link periods, which is 160 ns. Staging and sending together stay well under one microsecond. The block can therefore run alongside the next conversion without stalling acquisition. A load strobe that arrives while a frame is still pending is refused, and the refusal is flagged.

Top module: `link_frame_tx`

## Requirements
- R1: A frame carries 32 nibbles. Entry e (0..7) holds sample e for e < 3, taken from bits [16e+15:16e] of `samples_i`, and holds zero for e >= 3. Entries go out in the order 0 to 7. Within an entry the least-significant nibble goes first, and lane bit i carries nibble bit i.
- R2: While a frame is being sent, `lnk_clk_o` is 1 with the first nibble and toggles on every system cycle after that. This gives 16 full link periods, and the clock ends low.
- R3: After staging, transmission begins only after the first rising edge at which `ack_i` is sampled high. While `ack_i` stays low, the block holds the frame, and the lanes and the link clock stay at zero.
- R4: An accepted load is followed by exactly 8 staging cycles. With `ack_i` already high, the first nibble appears on the outputs after the 9th rising edge following the edge that sampled the load.
- R5: The link clock is low and all four lanes are zero whenever no frame is being sent, including directly after reset.
- R6: A load strobe sampled while a frame is pending (staging, waiting or sending) sets `overrun_o`, and its samples are discarded. The next accepted load clears `overrun_o`.
- R7: `busy_o` is high from the cycle after an accepted load through the last nibble. `done_o` is high for exactly one cycle, directly after the last nibble.
- R8: With `ack_i` high, `done_o` rises 41 cycles after the load-sampling edge, which is 205 ns at a 200 MHz clock.
- R9: A load strobe sampled in the cycle where `done_o` is high is accepted and starts a new frame.
- R10: Once sending has begun, `ack_i` has no effect until the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at twice the link clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load strobe for one set of samples |
| samples_i | input | 48 | Three samples; sample s in bits [16s+15:16s] |
| ack_i | input | 1 | Receiver acknowledge / ready |
| lnk_clk_o | output | 1 | Forwarded link clock |
| lnk_dat_o | output | 4 | Data lanes, one nibble per link-clock edge |
| busy_o | output | 1 | A frame is pending |
| done_o | output | 1 | One-cycle pulse after the last nibble |
| overrun_o | output | 1 | A load strobe was refused while a frame was pending |

## Verification
The frame path is exercised with several sample patterns: distinct per-nibble values, all-ones, alternating bits, and zeros. Distinct nibbles expose swapped entries, a reversed nibble order or a wrong lane mapping. The all-ones pattern shows where the zero padding starts. Acknowledge is tried in three ways: already high, held low for a long time, and dropped in the middle of a send. These separate the gating of the start from the behaviour once sending is under way. Load strobes are placed during staging, during the acknowledge wait and during sending, where they must be refused. One is placed in the done cycle, where it must be accepted. A cycle-level model checks every cycle, and directed latency measurements pin down the staging length and the total frame time.

// File: rtl/lft_pkg.sv
package lft_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_STAGE = 3'd1,
      ST_WAIT  = 3'd2,
      ST_SEND  = 3'd3,
      ST_DONE  = 3'd4
   } lft_state_e;
endpackage

// File: rtl/lft_ctrl.sv
module lft_ctrl
   import lft_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int NIB_CNT     = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load_i,
   input  logic                           ack_i,
   output logic                           accept_o,
   output logic                           stg_we_o,
   output logic [$clog2(NUM_ENTRIES)-1:0] stg_idx_o,
   output logic                           ser_first_o,
   output logic                           ser_step_o,
   output logic                           ser_clear_o,
   output logic [$clog2(NIB_CNT)-1:0]     ser_idx_o,
   output logic                           sending_o,
   output logic                           busy_o,
   output logic                           done_o,
   output logic                           overrun_o
);
   localparam int STG_W = $clog2(NUM_ENTRIES);
   localparam int CNT_W = $clog2(NIB_CNT);
   localparam logic [STG_W-1:0] STG_LAST = STG_W'(NUM_ENTRIES - 1);
   localparam logic [CNT_W-1:0] NIB_LAST = CNT_W'(NIB_CNT - 1);

   lft_state_e       state_q;
   logic [STG_W-1:0] stg_q;
   logic [CNT_W-1:0] nib_q;
   logic             ovr_q;
   logic             nib_last;

   assign accept_o = load_i && (state_q == ST_IDLE || state_q == ST_DONE);
   assign nib_last = (nib_q == NIB_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         stg_q   <= '0;
         nib_q   <= '0;
         ovr_q   <= 1'b0;
      end else begin
         if (accept_o)
            ovr_q <= 1'b0;
         else if (load_i)
            ovr_q <= 1'b1;
         unique case (state_q)
            ST_IDLE, ST_DONE: begin
               if (accept_o) begin
                  state_q <= ST_STAGE;
                  stg_q   <= '0;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            ST_STAGE: begin
               if (stg_q == STG_LAST)
                  state_q <= ST_WAIT;
               else
                  stg_q <= stg_q + 1'b1;
            end
            ST_WAIT: begin
               if (ack_i) begin
                  state_q <= ST_SEND;
                  nib_q   <= '0;
               end
            end
            ST_SEND: begin
               if (nib_last)
                  state_q <= ST_DONE;
               else
                  nib_q <= nib_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign stg_we_o    = (state_q == ST_STAGE);
   assign stg_idx_o   = stg_q;
   assign ser_first_o = (state_q == ST_WAIT) && ack_i;
   assign ser_step_o  = (state_q == ST_SEND) && !nib_last;
   assign ser_clear_o = (state_q == ST_SEND) && nib_last;
   assign ser_idx_o   = (state_q == ST_WAIT) ? '0 : CNT_W'(nib_q + 1'b1);
   assign sending_o   = (state_q == ST_SEND);
   assign busy_o      = (state_q == ST_STAGE) || (state_q == ST_WAIT) || (state_q == ST_SEND);
   assign done_o      = (state_q == ST_DONE);
   assign overrun_o   = ovr_q;

   // independent window counter for the staging length check
   logic [STG_W+1:0] win_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         win_q <= '0;
      else if (accept_o)
         win_q <= '0;
      else if (win_q != '1)
         win_q <= win_q + 1'b1;
   end

   // R4: staging lasts exactly NUM_ENTRIES cycles after an accepted load
   p_stage_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && $past(state_q) == ST_STAGE) |-> (win_q == (STG_W+2)'(NUM_ENTRIES)));

   // R3: no progress out of the wait state without acknowledge
   p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && !ack_i) |=> (state_q == ST_WAIT));

   // R6: a refused load leaves the overrun flag set
   p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && busy_o) |=> overrun_o);

   // R7: done is a single-cycle pulse
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

// File: rtl/lft_stager.sv
module lft_stager #(
   parameter int SAMPLE_W    = 16,
   parameter int NUM_SAMPLES = 3,
   parameter int NUM_ENTRIES = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cap_i,
   input  logic [NUM_SAMPLES*SAMPLE_W-1:0] samples_i,
   input  logic                            we_i,
   input  logic [$clog2(NUM_ENTRIES)-1:0]  idx_i,
   output logic [NUM_ENTRIES*SAMPLE_W-1:0] frame_o
);
   localparam int STG_W = $clog2(NUM_ENTRIES);

   logic [NUM_SAMPLES*SAMPLE_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (cap_i)
         hold_q <= samples_i;
   end

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      logic [SAMPLE_W-1:0] ent_q;
      logic [SAMPLE_W-1:0] ent_src;
      if (e < NUM_SAMPLES) begin : g_sample
         assign ent_src = hold_q[e*SAMPLE_W +: SAMPLE_W];
      end else begin : g_pad
         assign ent_src = '0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q <= '0;
         else if (we_i && idx_i == STG_W'(e))
            ent_q <= ent_src;
      end
      assign frame_o[e*SAMPLE_W +: SAMPLE_W] = ent_q;
   end
endmodule

// File: rtl/lft_serializer.sv
module lft_serializer #(
   parameter int LANES   = 4,
   parameter int FRAME_W = 128,
   parameter int CNT_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic               first_i,
   input  logic               step_i,
   input  logic               clear_i,
   input  logic [CNT_W-1:0]   idx_i,
   output logic               lnk_clk_o,
   output logic [LANES-1:0]   lnk_dat_o
);
   logic [LANES-1:0] nib;
   logic             lclk_q;
   logic [LANES-1:0] dat_q;

   assign nib = frame_i[idx_i*LANES +: LANES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lclk_q <= 1'b0;
         dat_q  <= '0;
      end else if (first_i) begin
         lclk_q <= 1'b1;
         dat_q  <= nib;
      end else if (step_i) begin
         lclk_q <= ~lclk_q;
         dat_q  <= nib;
      end else if (clear_i) begin
         lclk_q <= 1'b0;
         dat_q  <= '0;
      end
   end

   assign lnk_clk_o = lclk_q;
   assign lnk_dat_o = dat_q;
endmodule

// File: rtl/link_frame_tx.sv
module link_frame_tx #(
   parameter int SAMPLE_W    = 16,
   parameter int NUM_SAMPLES = 3,
   parameter int NUM_ENTRIES = 8,
   parameter int LANES       = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load_i,
   input  logic [NUM_SAMPLES*SAMPLE_W-1:0] samples_i,
   input  logic                            ack_i,
   output logic                            lnk_clk_o,
   output logic [LANES-1:0]                lnk_dat_o,
   output logic                            busy_o,
   output logic                            done_o,
   output logic                            overrun_o
);
   localparam int FRAME_W = NUM_ENTRIES * SAMPLE_W;
   localparam int NIB_CNT = FRAME_W / LANES;
   localparam int STG_W   = $clog2(NUM_ENTRIES);
   localparam int CNT_W   = $clog2(NIB_CNT);

   if (SAMPLE_W % LANES != 0) begin : g_bad_lanes
      $error("SAMPLE_W must be a multiple of LANES");
   end
   if (NUM_SAMPLES > NUM_ENTRIES || NUM_SAMPLES < 1) begin : g_bad_samples
      $error("NUM_SAMPLES must lie in 1..NUM_ENTRIES");
   end
   if ((NUM_ENTRIES & (NUM_ENTRIES - 1)) != 0 || NUM_ENTRIES < 2) begin : g_bad_entries
      $error("NUM_ENTRIES must be a power of two of at least 2");
   end
   if ((NIB_CNT % 2) != 0) begin : g_bad_nibbles
      $error("frame must hold an even number of nibbles");
   end

   logic             accept;
   logic             stg_we;
   logic [STG_W-1:0] stg_idx;
   logic             ser_first;
   logic             ser_step;
   logic             ser_clear;
   logic [CNT_W-1:0] ser_idx;
   logic             sending;
   logic [FRAME_W-1:0] frame;

   lft_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .NIB_CNT(NIB_CNT)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .ack_i(ack_i),
      .accept_o(accept), .stg_we_o(stg_we), .stg_idx_o(stg_idx),
      .ser_first_o(ser_first), .ser_step_o(ser_step), .ser_clear_o(ser_clear),
      .ser_idx_o(ser_idx), .sending_o(sending), .busy_o(busy_o),
      .done_o(done_o), .overrun_o(overrun_o)
   );

   lft_stager #(.SAMPLE_W(SAMPLE_W), .NUM_SAMPLES(NUM_SAMPLES), .NUM_ENTRIES(NUM_ENTRIES)) i_stager (
      .clk(clk), .rst_n(rst_n), .cap_i(accept), .samples_i(samples_i),
      .we_i(stg_we), .idx_i(stg_idx), .frame_o(frame)
   );

   lft_serializer #(.LANES(LANES), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_ser (
      .clk(clk), .rst_n(rst_n), .frame_i(frame), .first_i(ser_first),
      .step_i(ser_step), .clear_i(ser_clear), .idx_i(ser_idx),
      .lnk_clk_o(lnk_clk_o), .lnk_dat_o(lnk_dat_o)
   );

   // R5: link quiet whenever the controller is not sending
   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sending |-> (!lnk_clk_o && lnk_dat_o == '0));

   // R2: forwarded clock toggles on every cycle of a send
   p_clk_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sending && $past(sending)) |-> (lnk_clk_o != $past(lnk_clk_o)));

   // R2: a send always opens with the link clock high
   p_clk_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sending) |-> lnk_clk_o);
endmodule

// File: tb/test_link_frame_tx.sv
module test_link_frame_tx;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [47:0] samples = '0;
   logic        ack = 1'b0;
   logic        lnk_clk;
   logic [3:0]  lnk_dat;
   logic        busy, done, overrun;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   link_frame_tx i_link_frame_tx (
      .clk(clk), .rst_n(rst_n), .load_i(load), .samples_i(samples), .ack_i(ack),
      .lnk_clk_o(lnk_clk), .lnk_dat_o(lnk_dat), .busy_o(busy), .done_o(done),
      .overrun_o(overrun)
   );

   // behavioural reference: phase 0 idle, 1 staging, 2 waiting, 3 sending, 4 done
   int       ph = 0;
   int       sc = 0;
   int       k = 0;
   bit       m_ovr = 0;
   bit [3:0] q[$];

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         ph = 0; m_ovr = 0; q.delete();
      end else begin
         bit acc;
         acc = load && (ph == 0 || ph == 4);
         if (load && !acc) m_ovr = 1;
         case (ph)
            0, 4: begin
               if (acc) begin
                  q.delete();
                  for (int w = 0; w < 8; w++)
                     for (int n = 0; n < 4; n++)
                        q.push_back(w < 3 ? samples[w*16 + n*4 +: 4] : 4'h0);
                  m_ovr = 0; ph = 1; sc = 0;
               end else ph = 0;
            end
            1: begin sc++; if (sc == 8) ph = 2; end
            2: if (ack) begin ph = 3; k = 0; end
            3: begin k++; if (k == 32) ph = 4; end
            default: ph = 0;
         endcase
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2", "lnk_clk", lnk_clk, (ph == 3) ? int'(k % 2 == 0) : 0);
         chk("R1", "lnk_dat", lnk_dat, (ph == 3) ? int'(q[k]) : 0);
         chk("R7", "busy", busy, int'(ph >= 1 && ph <= 3));
         chk("R7", "done", done, int'(ph == 4));
         chk("R6", "overrun", overrun, m_ovr);
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         if (cyc > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
            finish_run();
         end
      end
   end

   task automatic pulse_load(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
      @(negedge clk);
      load = 1'b1; samples = {c, b, a};
      @(negedge clk);
      load = 1'b0; samples = '0;
   endtask

   task automatic wait_idle();
      while (busy || done) @(negedge clk);
   endtask

   initial begin
      int first_at, done_at;
      repeat (3) @(negedge clk);
      // R5: reset state
      chk("R5", "reset lnk_clk", lnk_clk, 0);
      chk("R5", "reset lnk_dat", lnk_dat, 0);
      chk("R7", "reset busy", busy, 0);
      chk("R6", "reset overrun", overrun, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 / R8: latency with acknowledge already high, distinct nibbles (R1)
      ack = 1'b1;
      @(negedge clk);
      load = 1'b1; samples = {16'hCDEF, 16'h89AB, 16'h4567};
      first_at = -1; done_at = -1;
      for (int t = 0; t < 60; t++) begin
         @(negedge clk);
         load = 1'b0;
         if (lnk_clk && first_at < 0) first_at = t;
         if (done && done_at < 0) done_at = t;
      end
      chk("R4", "first nibble delay", first_at, 9);
      chk("R8", "done delay", done_at, 41);

      // R3: acknowledge held low keeps the frame back
      ack = 1'b0;
      pulse_load(16'hFFFF, 16'hFFFF, 16'hFFFF);
      repeat (40) begin
         @(negedge clk);
         chk("R3", "lanes quiet while waiting", {lnk_clk, lnk_dat}, 0);
      end
      chk("R3", "still pending", busy, 1);
      // R6: load while waiting is refused, frame keeps the all-ones data
      pulse_load(16'h1111, 16'h2222, 16'h3333);
      chk("R6", "overrun after refused load", overrun, 1);
      ack = 1'b1;
      // R10: drop acknowledge in the middle of the send
      repeat (10) @(negedge clk);
      ack = 1'b0;
      wait_idle();

      // R6: load during staging, then again during sending; alternating bits
      ack = 1'b1;
      pulse_load(16'hA5A5, 16'h5A5A, 16'h0F0F);
      repeat (2) @(negedge clk);
      pulse_load(16'hDEAD, 16'hBEEF, 16'hCAFE);
      repeat (12) @(negedge clk);
      pulse_load(16'h0001, 16'h0002, 16'h0003);
      // R9: load in the done cycle is accepted
      while (!done) @(negedge clk);
      load = 1'b1; samples = {16'h7654, 16'h3210, 16'h8421};
      @(negedge clk);
      load = 1'b0;
      chk("R9", "accepted in done cycle", busy, 1);
      chk("R6", "overrun cleared by accepted load", overrun, 0);
      wait_idle();

      // zeros pattern
      pulse_load(16'h0000, 16'h0000, 16'h0000);
      wait_idle();
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule